// File: doc/BRIEF.md
# SPI Serial Memory Command Front-End

This block is an SPI target that sits in front of a small byte-wide memory of 1 KB or 2 KB. It runs on a fast system clock and samples the serial clock, chip select and data input through two-flop synchronizers. From those samples it detects clock edges and the start and end of each chip-select frame. A frame starts with an 8-bit command. Six command values are recognised: set write enable, clear write enable, status read, status write, array read and array write. Any other value makes the rest of the frame inert.

An array read streams bytes out from an auto-incrementing pointer that wraps over the whole array. An array write collects bytes into a 32-byte page buffer, and the offset within the page wraps. A separate protection and program-cycle controller decides whether a write may proceed. That controller reports when an internal write cycle is busy and receives single-cycle requests when a frame ends. The array and the page buffer are plain registers inside the block. On an accepted program request, the buffered bytes are copied into the array.

Top module: `spi_mem_frontend`

## Requirements
- R1: `miso_oe` is 1 only while the synchronized chip select is low. It falls within 3 system clocks of `cs_n` rising, and `miso` is 0 outside a read phase.
- R2: Command 0x06 raises `wel_set` for one cycle when `cs_n` rises. This happens only if exactly 8 bits were clocked in the frame: 7 bits or 9 bits give no pulse.
- R3: Command 0x04 raises `wel_clr` for one cycle after its eighth bit. A command value outside {0x01..0x06} is ignored along with every later bit of the frame.
- R4: Commands 0x02 and 0x03 are followed by a 16-bit address, MSB first. Only the low `ADDR_BITS` bits are used. For a write, `wr_addr` shows the start address. `prog_start` pulses on the `cs_n` rise when at least one complete data byte arrived and `wr_allow` is 1.
- R5: A read returns the array byte at the address, MSB first, with each bit driven after a falling serial clock edge. The first data bit follows the falling edge that comes after the last address bit.
- R6: During a write, only the low 5 address bits advance. A 33rd byte lands at the page offset where the frame started, and the last byte written to an offset wins.
- R7: A read pointer past the top address continues at address 0.
- R8: With `wr_allow` at 0 when the frame ends, there is no `prog_start` and the array keeps its contents.
- R9: A trailing partial data byte is dropped. A write frame with no complete data byte gives no `prog_start`.
- R10: While `busy` is 1 at the end of the command byte, every command except status read is ignored: no pulses, and `miso` stays 0.
- R11: Command 0x05 returns `status_in` for every byte of the frame, busy or not. Command 0x01 puts its first data byte on `wrsr_data` and pulses `wrsr_start` at the `cs_n` rise, but only if a full data byte arrived.
- R12: Both serial clock idle levels (mode 0, low; mode 3, high) give the same behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| mosi | input | 1 | Serial data from host |
| busy | input | 1 | Internal write cycle in progress (from controller) |
| wr_allow | input | 1 | Controller grants a write at `wr_addr` |
| status_in | input | 8 | Status byte supplied by the controller |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for `miso` |
| wel_set | output | 1 | Pulse: set write enable |
| wel_clr | output | 1 | Pulse: clear write enable |
| wrsr_start | output | 1 | Pulse: status write requested |
| wrsr_data | output | 8 | Status byte received |
| prog_start | output | 1 | Pulse: array program cycle started |
| wr_addr | output | ADDR_BITS | Start address of the current write |

## Verification
Every serial event reaches a registered output 3 system clocks after the pin changes: two synchronizer stages, then the edge-detect register. The bench holds each serial clock phase for 8 system clocks and samples `miso` just before it raises the serial clock, so a bit driven on the preceding falling edge has settled. After raising `cs_n` it waits 10 clocks before comparing the frame-end pulse counters, which it accumulates on every clock. Busy and grant inputs are held for the whole frame.

// File: rtl/spi_mem_pkg.sv
`timescale 1ns/1ps
package spi_mem_pkg;

    localparam int PG_BITS  = 5;
    localparam int PG_BYTES = 1 << PG_BITS;

    localparam logic [7:0] OPC_WRSR = 8'h01;
    localparam logic [7:0] OPC_WR   = 8'h02;
    localparam logic [7:0] OPC_RD   = 8'h03;
    localparam logic [7:0] OPC_WRDI = 8'h04;
    localparam logic [7:0] OPC_RDSR = 8'h05;
    localparam logic [7:0] OPC_WREN = 8'h06;

    typedef enum logic [3:0] {
        PH_IDLE, PH_CMD, PH_ADDR, PH_RDAT, PH_WDAT,
        PH_STRD, PH_STWR, PH_WEN, PH_SKIP
    } phase_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic cs_start;
        logic cs_end;
        logic cs_act;
        logic din;
    } spi_evt_t;

    function automatic phase_e decode_cmd(input logic [7:0] op, input logic busy);
        if (busy && op != OPC_RDSR) return PH_SKIP;
        case (op)
            OPC_WREN:       return PH_WEN;
            OPC_RDSR:       return PH_STRD;
            OPC_WRSR:       return PH_STWR;
            OPC_RD, OPC_WR: return PH_ADDR;
            default:        return PH_SKIP;
        endcase
    endfunction

endpackage

// File: rtl/spi_edge_sync.sv
`timescale 1ns/1ps
module spi_edge_sync
    import spi_mem_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sck,
    input  logic     cs_n,
    input  logic     mosi,
    output spi_evt_t evt
);
    logic [2:0] sck_p;
    logic [2:0] cs_p;
    logic [1:0] din_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            cs_p  <= '1;
            din_p <= '0;
        end else begin
            sck_p <= {sck_p[1:0], sck};
            cs_p  <= {cs_p[1:0], cs_n};
            din_p <= {din_p[0], mosi};
        end
    end

    assign evt.rise     =  sck_p[1] & ~sck_p[2];
    assign evt.fall     = ~sck_p[1] &  sck_p[2];
    assign evt.cs_start = ~cs_p[1]  &  cs_p[2];
    assign evt.cs_end   =  cs_p[1]  & ~cs_p[2];
    assign evt.cs_act   = ~cs_p[1];
    assign evt.din      =  din_p[1];

endmodule

// File: rtl/spi_page_store.sv
`timescale 1ns/1ps
module spi_page_store
    import spi_mem_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_clr,
    input  logic               buf_we,
    input  logic [PG_BITS-1:0] buf_idx,
    input  logic [7:0]         buf_data,
    input  logic               commit,
    input  logic [AW-PG_BITS-1:0] commit_page,
    input  logic [AW-1:0]      rd_addr,
    output logic [7:0]         rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [7:0]          mem_q  [DEPTH];
    logic [7:0]          pbuf_q [PG_BYTES];
    logic [PG_BYTES-1:0] valid_q;

    always_ff @(posedge clk) begin
        if (rst)            valid_q <= '0;
        else if (frame_clr) valid_q <= '0;
        else if (buf_we)    valid_q[buf_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (buf_we) pbuf_q[buf_idx] <= buf_data;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < PG_BYTES; i++) begin
            if (commit && valid_q[i])
                mem_q[{commit_page, PG_BITS'(i)}] <= pbuf_q[i];
        end
    end

    assign rd_data = mem_q[rd_addr];

    AST_COMMIT_DATA: assert property (@(posedge clk) disable iff (rst)
        commit |-> (valid_q != '0)); // R9

endmodule

// File: rtl/spi_cmd_fsm.sv
`timescale 1ns/1ps
module spi_cmd_fsm
    import spi_mem_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  spi_evt_t           evt,
    input  logic               busy,
    input  logic               wr_allow,
    input  logic [7:0]         status_in,
    input  logic [7:0]         rd_data,
    output logic [AW-1:0]      ptr,
    output logic [AW-1:0]      start_addr,
    output logic               frame_clr,
    output logic               buf_we,
    output logic [PG_BITS-1:0] buf_idx,
    output logic [7:0]         buf_data,
    output logic               commit,
    output logic               wel_set,
    output logic               wel_clr,
    output logic               wrsr_start,
    output logic [7:0]         wrsr_data,
    output logic               miso,
    output logic               miso_oe
);
    localparam logic [AW-1:0] PTR_ONE = AW'(1);

    phase_e          phase_q;
    logic [3:0]      cnt_q;
    logic [AW-2:0]   sh_q;
    logic [AW-1:0]   sh_next;
    logic            is_wr_q;
    logic            got_q;
    logic [2:0]      txbit_q;
    logic [7:0]      tx_q;
    logic [7:0]      src;

    assign sh_next = {sh_q, evt.din};
    assign src     = (phase_q == PH_STRD) ? status_in : rd_data;
    assign miso_oe = evt.cs_act;

    always_ff @(posedge clk) begin
        wel_set    <= 1'b0;
        wel_clr    <= 1'b0;
        wrsr_start <= 1'b0;
        commit     <= 1'b0;
        buf_we     <= 1'b0;
        frame_clr  <= 1'b0;
        if (rst) begin
            phase_q    <= PH_IDLE;
            cnt_q      <= '0;
            sh_q       <= '0;
            is_wr_q    <= 1'b0;
            got_q      <= 1'b0;
            ptr        <= '0;
            start_addr <= '0;
            txbit_q    <= '0;
            tx_q       <= '0;
            miso       <= 1'b0;
            buf_idx    <= '0;
            buf_data   <= '0;
            wrsr_data  <= '0;
        end else if (evt.cs_end) begin
            if (phase_q == PH_WEN)                         wel_set    <= 1'b1;
            if (phase_q == PH_WDAT && got_q && wr_allow)   commit     <= 1'b1;
            if (phase_q == PH_STWR && got_q)               wrsr_start <= 1'b1;
            phase_q <= PH_IDLE;
            miso    <= 1'b0;
        end else if (evt.cs_start) begin
            phase_q   <= PH_CMD;
            cnt_q     <= '0;
            got_q     <= 1'b0;
            txbit_q   <= '0;
            miso      <= 1'b0;
            frame_clr <= 1'b1;
        end else if (evt.rise) begin
            sh_q  <= sh_next[AW-2:0];
            cnt_q <= cnt_q + 4'd1;
            case (phase_q)
                PH_CMD: if (cnt_q == 4'd7) begin
                    cnt_q   <= '0;
                    phase_q <= decode_cmd(sh_next[7:0], busy);
                    is_wr_q <= (sh_next[7:0] == OPC_WR);
                    if (sh_next[7:0] == OPC_WRDI && !busy) wel_clr <= 1'b1;
                end
                PH_ADDR: if (cnt_q == 4'd15) begin
                    cnt_q      <= '0;
                    ptr        <= sh_next;
                    start_addr <= sh_next;
                    phase_q    <= is_wr_q ? PH_WDAT : PH_RDAT;
                end
                PH_WDAT: if (cnt_q == 4'd7) begin
                    cnt_q    <= '0;
                    buf_we   <= 1'b1;
                    buf_idx  <= ptr[PG_BITS-1:0];
                    buf_data <= sh_next[7:0];
                    ptr[PG_BITS-1:0] <= ptr[PG_BITS-1:0] + PG_BITS'(1);
                    got_q    <= 1'b1;
                end
                PH_STWR: if (cnt_q == 4'd7 && !got_q) begin
                    wrsr_data <= sh_next[7:0];
                    got_q     <= 1'b1;
                end
                PH_WEN:  phase_q <= PH_SKIP;
                default: ;
            endcase
        end else if (evt.fall) begin
            if (phase_q == PH_RDAT || phase_q == PH_STRD) begin
                if (txbit_q == 3'd0) begin
                    miso <= src[7];
                    tx_q <= {src[6:0], 1'b0};
                    if (phase_q == PH_RDAT) ptr <= ptr + PTR_ONE;
                end else begin
                    miso <= tx_q[7];
                    tx_q <= {tx_q[6:0], 1'b0};
                end
                txbit_q <= txbit_q + 3'd1;
            end
        end
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wel_set, wel_clr, commit, wrsr_start})); // R2
    AST_END_ONLY: assert property (@(posedge clk) disable iff (rst)
        (commit || wel_set || wrsr_start) |-> $past(evt.cs_end)); // R4
    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_WDAT && $past(phase_q) == PH_WDAT)
            |-> ptr[AW-1:PG_BITS] == $past(ptr[AW-1:PG_BITS])); // R6
    AST_WCLR_IDLE: assert property (@(posedge clk) disable iff (rst)
        wel_clr |-> !$past(busy)); // R10

endmodule

// File: rtl/spi_mem_frontend.sv
`timescale 1ns/1ps
module spi_mem_frontend
    import spi_mem_pkg::*;
#(
    parameter int ADDR_BITS = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sck,
    input  logic                 cs_n,
    input  logic                 mosi,
    input  logic                 busy,
    input  logic                 wr_allow,
    input  logic [7:0]           status_in,
    output logic                 miso,
    output logic                 miso_oe,
    output logic                 wel_set,
    output logic                 wel_clr,
    output logic                 wrsr_start,
    output logic [7:0]           wrsr_data,
    output logic                 prog_start,
    output logic [ADDR_BITS-1:0] wr_addr
);
    spi_evt_t             evt;
    logic [ADDR_BITS-1:0] ptr;
    logic                 frame_clr;
    logic                 buf_we;
    logic [PG_BITS-1:0]   buf_idx;
    logic [7:0]           buf_data;
    logic [7:0]           rd_data;

    spi_edge_sync u_sync (
        .clk  (clk),
        .rst  (rst),
        .sck  (sck),
        .cs_n (cs_n),
        .mosi (mosi),
        .evt  (evt)
    );

    spi_cmd_fsm #(.AW(ADDR_BITS)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .evt        (evt),
        .busy       (busy),
        .wr_allow   (wr_allow),
        .status_in  (status_in),
        .rd_data    (rd_data),
        .ptr        (ptr),
        .start_addr (wr_addr),
        .frame_clr  (frame_clr),
        .buf_we     (buf_we),
        .buf_idx    (buf_idx),
        .buf_data   (buf_data),
        .commit     (prog_start),
        .wel_set    (wel_set),
        .wel_clr    (wel_clr),
        .wrsr_start (wrsr_start),
        .wrsr_data  (wrsr_data),
        .miso       (miso),
        .miso_oe    (miso_oe)
    );

    spi_page_store #(.AW(ADDR_BITS)) u_store (
        .clk         (clk),
        .rst         (rst),
        .frame_clr   (frame_clr),
        .buf_we      (buf_we),
        .buf_idx     (buf_idx),
        .buf_data    (buf_data),
        .commit      (prog_start),
        .commit_page (ptr[ADDR_BITS-1:PG_BITS]),
        .rd_addr     (ptr),
        .rd_data     (rd_data)
    );

    AST_OE_OFF: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !miso_oe); // R1

endmodule

// File: tb/tb_spi_mem_frontend.sv
`timescale 1ns/1ps
module tb_spi_mem_frontend;
    localparam int AW   = 10;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic busy = 1'b0, wr_allow = 1'b1;
    logic [7:0] status_in = 8'h00;
    logic miso, miso_oe, wel_set, wel_clr, wrsr_start, prog_start;
    logic [7:0] wrsr_data;
    logic [AW-1:0] wr_addr;

    int n_chk = 0, n_err = 0;
    int n_wen = 0, n_wdi = 0, n_wsr = 0, n_prog = 0;
    logic mode3 = 1'b0;
    logic [7:0] rbuf [64];
    logic [7:0] wbuf [64];
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_mem_frontend #(.ADDR_BITS(AW)) dut (
        .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .busy(busy), .wr_allow(wr_allow), .status_in(status_in),
        .miso(miso), .miso_oe(miso_oe), .wel_set(wel_set), .wel_clr(wel_clr),
        .wrsr_start(wrsr_start), .wrsr_data(wrsr_data),
        .prog_start(prog_start), .wr_addr(wr_addr)
    );

    always @(posedge clk) if (!rst) begin
        if (wel_set)    n_wen++;
        if (wel_clr)    n_wdi++;
        if (wrsr_start) n_wsr++;
        if (prog_start) n_prog++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got=%0h expected=%0h", req, got, exp);
        end
    endtask

    task automatic fbegin();
        sck = mode3;
        tick(HALF);
        cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic fend();
        sck = mode3;
        tick(HALF);
        cs_n = 1'b1;
        tick(10);
    endtask

    task automatic xbit(input logic b, output logic r);
        sck = 1'b0;
        mosi = b;
        tick(HALF);
        r = miso;
        sck = 1'b1;
        tick(HALF);
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) xbit(t[i], r[i]);
    endtask

    task automatic xbits(input logic [7:0] t, input int n);
        logic r;
        for (int i = 7; i > 7 - n; i--) xbit(t[i], r);
    endtask

    task automatic mem_write(input logic [15:0] a, input int n, input int extra_bits);
        logic [7:0] r;
        fbegin();
        xbyte(8'h02, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        for (int k = 0; k < n; k++) xbyte(wbuf[k], r);
        if (extra_bits > 0) xbits(8'hFF, extra_bits);
        fend();
    endtask

    task automatic mem_read(input logic [15:0] a, input int n);
        logic [7:0] r;
        fbegin();
        xbyte(8'h03, r); xbyte(a[15:8], r); xbyte(a[7:0], r);
        for (int k = 0; k < n; k++) begin xbyte(8'h00, r); rbuf[k] = r; end
        fend();
    endtask

    task automatic t_reset();
        check("R1 reset oe", miso_oe, 0);
        check("R1 reset miso", miso, 0);
        check("R4 reset prog", n_prog, 0);
    endtask

    task automatic t_oe();
        fbegin();
        check("R1 oe in frame", miso_oe, 1);
        check("R1 miso idle", miso, 0);
        cs_n = 1'b1;
        tick(3);
        check("R1 oe after cs", miso_oe, 0);
        tick(10);
    endtask

    task automatic t_wren();
        logic [7:0] r;
        int b;
        b = n_wen;
        fbegin(); xbyte(8'h06, r); fend();
        check("R2 wren 8 bits", n_wen, b + 1);
        fbegin(); xbyte(8'h06, r); xbits(8'h00, 1); fend();
        check("R2 wren 9 bits", n_wen, b + 1);
        fbegin(); xbits(8'h0C, 7); fend();
        check("R2 wren 7 bits", n_wen, b + 1);
    endtask

    task automatic t_wrdi_unknown();
        logic [7:0] r;
        int bd, be;
        bd = n_wdi; be = n_wen;
        fbegin(); xbyte(8'h04, r); fend();
        check("R3 wrdi pulse", n_wdi, bd + 1);
        fbegin(); xbyte(8'h07, r); xbyte(8'h06, r); xbyte(8'h04, r); fend();
        check("R3 unknown wen", n_wen, be);
        check("R3 unknown wdi", n_wdi, bd + 1);
    endtask

    task automatic t_write_read();
        int bp;
        bp = n_prog;
        for (int k = 0; k < 4; k++) wbuf[k] = 8'hA0 + 8'(k);
        mem_write(16'hFC40, 4, 0);
        check("R4 prog pulse", n_prog, bp + 1);
        check("R4 wr_addr", wr_addr, 10'h040);
        mode3 = 1'b1;
        mem_read(16'h0040, 4);
        for (int k = 0; k < 4; k++) check("R5 R12 read mode3", rbuf[k], 8'hA0 + 8'(k));
        mode3 = 1'b0;
        mem_read(16'h0441, 1);
        check("R5 dont-care addr", rbuf[0], 8'hA1);
    endtask

    task automatic t_wraps();
        wbuf[0] = 8'h5A; wbuf[1] = 8'hA5;
        mem_write(16'h0000, 2, 0);
        for (int k = 0; k < 34; k++) wbuf[k] = 8'h10 + 8'(k);
        mem_write(16'h03FE, 34, 0);
        mem_read(16'h03E0, 1);
        check("R6 page offset0", rbuf[0], 8'h12);
        mem_read(16'h03FE, 4);
        check("R6 overwritten 30", rbuf[0], 8'h30);
        check("R6 overwritten 31", rbuf[1], 8'h31);
        check("R7 wrap to 0", rbuf[2], 8'h5A);
        check("R7 wrap to 1", rbuf[3], 8'hA5);
    endtask

    task automatic t_denied();
        int bp;
        bp = n_prog;
        wr_allow = 1'b0;
        wbuf[0] = 8'hEE;
        mem_write(16'h0040, 1, 0);
        wr_allow = 1'b1;
        check("R8 no prog", n_prog, bp);
        mem_read(16'h0040, 1);
        check("R8 array kept", rbuf[0], 8'hA0);
    endtask

    task automatic t_partial();
        int bp;
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        mem_write(16'h0100, 2, 0);
        bp = n_prog;
        wbuf[0] = 8'h77;
        mem_write(16'h0100, 1, 3);
        check("R9 prog one byte", n_prog, bp + 1);
        mem_read(16'h0100, 2);
        check("R9 full byte", rbuf[0], 8'h77);
        check("R9 partial dropped", rbuf[1], 8'h22);
        mem_write(16'h0100, 0, 5);
        check("R9 no full byte", n_prog, bp + 1);
    endtask

    task automatic t_busy();
        logic [7:0] r;
        int be;
        be = n_wen;
        busy = 1'b1;
        status_in = 8'h8D;
        fbegin(); xbyte(8'h06, r); fend();
        check("R10 wren busy", n_wen, be);
        mem_read(16'h0040, 1);
        check("R10 read busy", rbuf[0], 8'h00);
        mode3 = 1'b1;
        fbegin(); xbyte(8'h05, r); xbyte(8'h00, r);
        check("R11 status byte", r, 8'h8D);
        xbyte(8'h00, r);
        check("R11 status repeat", r, 8'h8D);
        fend();
        mode3 = 1'b0;
        busy = 1'b0;
    endtask

    task automatic t_wrsr();
        logic [7:0] r;
        int bs;
        bs = n_wsr;
        fbegin(); xbyte(8'h01, r); xbyte(8'h8C, r); fend();
        check("R11 wrsr pulse", n_wsr, bs + 1);
        check("R11 wrsr data", wrsr_data, 8'h8C);
        fbegin(); xbyte(8'h01, r); xbits(8'hF0, 4); fend();
        check("R11 wrsr short", n_wsr, bs + 1);
    endtask

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_oe();
        t_wren();
        t_wrdi_unknown();
        t_write_read();
        t_wraps();
        t_denied();
        t_partial();
        t_busy();
        t_wrsr();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: got=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule